// File: doc/BRIEF.md
# Selectable-Precision Taint Tracking Gate Array

This block is a purely combinational array of two-input gates, each one an AND or an OR as chosen by a per-lane type bit. Alongside its data result, every gate computes a shadow "taint" bit. The taint bit records whether tainted input information can influence that gate's output. A per-lane two-bit precision code picks one of four shadow formulas at run time. One formula is exact. The other three are cheaper and more conservative: each one may flag taint where the exact formula would not, but never misses a real flow.

A weighted cost output adds up, over all lanes, a gate-count estimate for the formulas currently chosen. An exploration engine can use this sum to trade tracking precision against logic area. The array also carries a group of inverter lanes, whose taint passes straight through. Each gate input can be declared a constant. A constant input's taint comes from a single labelling bit and not from its taint pin.

Top module: `taint_gate_array`

## Requirements
- R1: Lane i drives `y[i] = a&b` when `kind[i]` is 0 (AND) and `y[i] = a|b` when `kind[i]` is 1 (OR).
- R2: Precision code 2'b00 (exact): AND gives `ty = (a&tb)|(b&ta)|(ta&tb)`; OR gives `ty = (~a&tb)|(~b&ta)|(ta&tb)`.
- R3: Precision code 2'b10 (first relaxed form): AND gives `ty = tb|(b&ta)`; OR gives `ty = ta|(~a&tb)`.
- R4: Precision code 2'b01 (second relaxed form): AND gives `ty = ta|(a&tb)`; OR gives `ty = tb|(~b&ta)`.
- R5: Precision code 2'b11 (coarsest) gives `ty = ta|tb` for both gate kinds. Lane i's code sits at `prec[2*i+1:2*i]`.
- R6: The array is conservative. For every input combination, each relaxed form reports taint wherever the exact form does. When neither effective input taint is set, `ty` is 0 under every code.
- R7: `cost` equals the sum over lanes of a weight chosen by the lane's code: 5 for 2'b00, 2 for 2'b10, 2 for 2'b01 and 1 for 2'b11.
- R8: `cost` is at least ceil(log2(5*N+1)) bits wide. It reports 5*N exactly when every lane is exact, with no wrap, including when N is odd.
- R9: Inverter lane j drives `inv_y[j] = ~inv_a[j]` and `inv_ty[j] = inv_ta[j]`.
- R10: When `a_const[i]` (or `b_const[i]`) is 1, that input's taint is taken from `taint_consts`, and `ta[i]` (or `tb[i]`) has no effect. With `taint_consts` at 0, the constant input counts as clean; at 1, it counts as tainted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| kind | input | N | Gate kind per lane, 0 = AND, 1 = OR |
| prec | input | 2*N | Precision code per lane, two bits each |
| a | input | N | First data input per lane |
| b | input | N | Second data input per lane |
| ta | input | N | Taint of a per lane |
| tb | input | N | Taint of b per lane |
| a_const | input | N | Marks input a as a constant |
| b_const | input | N | Marks input b as a constant |
| taint_consts | input | 1 | Taint label given to constant inputs |
| inv_a | input | NINV | Inverter data inputs |
| inv_ta | input | NINV | Inverter taint inputs |
| y | output | N | Gate data outputs |
| ty | output | N | Gate taint outputs |
| inv_y | output | NINV | Inverter data outputs |
| inv_ty | output | NINV | Inverter taint outputs |
| cost | output | COST_W | Summed area weight of the chosen formulas |

## Verification
The taint formula selection and the cost sum both respond to the same precision code, so changing one lane's code changes `ty` and `cost` together. The bench sets mixed codes across all lanes and judges both results together. With an odd lane count, the last partial sum passes through the tree and must still arrive in the total. Constant labelling and formula choice also act on the same lane at once. A raw taint pin is driven opposite to the label, and the lane's `ty` shows which source won.

// File: rtl/taint_pkg.sv
package taint_pkg;
   localparam int WEIGHT_W      = 3;
   localparam int WT_EXACT      = 5;
   localparam int WT_RELAX_FWD  = 2;
   localparam int WT_RELAX_REV  = 2;
   localparam int WT_COARSE     = 1;

   typedef enum logic [1:0] {
      PREC_EXACT  = 2'b00,
      PREC_RELAX2 = 2'b01,
      PREC_RELAX1 = 2'b10,
      PREC_COARSE = 2'b11
   } prec_e;

   function automatic int min_cost_width(input int lanes);
      return $clog2(WT_EXACT * lanes + 1);
   endfunction
endpackage

// File: rtl/taint_gate_cell.sv
module taint_gate_cell
   import taint_pkg::*;
(
   input  logic                is_or,
   input  logic [1:0]          sel,
   input  logic                a,
   input  logic                b,
   input  logic                ta,
   input  logic                tb,
   output logic                y,
   output logic                ty,
   output logic [WEIGHT_W-1:0] weight
);
   logic xa, xb;
   logic exact_t, fwd_t, rev_t, coarse_t;
   logic relax1_t, relax2_t;
   logic pair_lo, pair_hi;
   logic [WEIGHT_W-1:0] w_lo, w_hi;

   // OR gates are tracked through their inverted inputs (dual of AND)
   assign xa = is_or ? ~a : a;
   assign xb = is_or ? ~b : b;
   assign y  = is_or ? (a | b) : (a & b);

   assign exact_t  = (xa & tb) | (xb & ta) | (ta & tb);
   assign fwd_t    = ta | (xa & tb);
   assign rev_t    = tb | (xb & ta);
   assign coarse_t = ta | tb;

   // Relaxed forms swap roles between the two gate kinds
   assign relax1_t = is_or ? fwd_t : rev_t;
   assign relax2_t = is_or ? rev_t : fwd_t;

   // Two mux levels: sel[1] inside each pair, sel[0] between pairs
   assign pair_lo = sel[1] ? relax1_t : exact_t;
   assign pair_hi = sel[1] ? coarse_t : relax2_t;
   assign ty      = sel[0] ? pair_hi : pair_lo;

   assign w_lo   = sel[1] ? WEIGHT_W'(WT_RELAX_FWD) : WEIGHT_W'(WT_EXACT);
   assign w_hi   = sel[1] ? WEIGHT_W'(WT_COARSE)    : WEIGHT_W'(WT_RELAX_REV);
   assign weight = sel[0] ? w_hi : w_lo;
endmodule

// File: rtl/taint_cost_tree.sv
module taint_cost_tree #(
   parameter int CNT = 1,
   parameter int W   = 4
) (
   input  logic [CNT*W-1:0] leaves,
   output logic [W-1:0]     total
);
   if (CNT < 1) begin : g_bad
      $error("taint_cost_tree: CNT must be at least 1");
   end

   if (CNT == 1) begin : g_leaf
      assign total = leaves;
   end else begin : g_level
      localparam int NXT = (CNT + 1) / 2;
      logic [NXT*W-1:0] nxt;
      for (genvar i = 0; i < CNT / 2; i++) begin : g_pair
         assign nxt[i*W +: W] = leaves[(2*i)*W +: W] + leaves[(2*i+1)*W +: W];
      end
      if (CNT % 2 == 1) begin : g_odd
         // last element of an odd level rides up unchanged
         assign nxt[(NXT-1)*W +: W] = leaves[(CNT-1)*W +: W];
      end
      taint_cost_tree #(.CNT(NXT), .W(W)) u_next (
         .leaves (nxt),
         .total  (total)
      );
   end
endmodule

// File: rtl/taint_gate_array.sv
module taint_gate_array
   import taint_pkg::*;
#(
   parameter int N      = 7,
   parameter int NINV   = 2,
   parameter int COST_W = min_cost_width(N)
) (
   input  logic [N-1:0]      kind,
   input  logic [2*N-1:0]    prec,
   input  logic [N-1:0]      a,
   input  logic [N-1:0]      b,
   input  logic [N-1:0]      ta,
   input  logic [N-1:0]      tb,
   input  logic [N-1:0]      a_const,
   input  logic [N-1:0]      b_const,
   input  logic              taint_consts,
   input  logic [NINV-1:0]   inv_a,
   input  logic [NINV-1:0]   inv_ta,
   output logic [N-1:0]      y,
   output logic [N-1:0]      ty,
   output logic [NINV-1:0]   inv_y,
   output logic [NINV-1:0]   inv_ty,
   output logic [COST_W-1:0] cost
);
   localparam int MIN_W = min_cost_width(N);

   if (N < 1) begin : g_chk_n
      $error("taint_gate_array: N must be at least 1");
   end
   if (NINV < 1) begin : g_chk_ninv
      $error("taint_gate_array: NINV must be at least 1");
   end
   if (COST_W < MIN_W) begin : g_chk_w
      $error("taint_gate_array: COST_W too narrow for all-exact sum");
   end

   logic [N*COST_W-1:0] weights;

   for (genvar i = 0; i < N; i++) begin : g_lane
      logic                ta_eff, tb_eff;
      logic [WEIGHT_W-1:0] w;

      assign ta_eff = a_const[i] ? taint_consts : ta[i];
      assign tb_eff = b_const[i] ? taint_consts : tb[i];

      taint_gate_cell u_cell (
         .is_or  (kind[i]),
         .sel    (prec[2*i +: 2]),
         .a      (a[i]),
         .b      (b[i]),
         .ta     (ta_eff),
         .tb     (tb_eff),
         .y      (y[i]),
         .ty     (ty[i]),
         .weight (w)
      );
      assign weights[i*COST_W +: COST_W] = COST_W'(w);
   end

   for (genvar j = 0; j < NINV; j++) begin : g_inv
      assign inv_y[j]  = ~inv_a[j];
      assign inv_ty[j] = inv_ta[j];
   end

   taint_cost_tree #(.CNT(N), .W(COST_W)) u_tree (
      .leaves (weights),
      .total  (cost)
   );
endmodule

// File: rtl/taint_gate_array_chk.sv
module taint_gate_array_chk #(
   parameter int N      = 7,
   parameter int NINV   = 2,
   parameter int COST_W = 6
) (
   input logic [N-1:0]      kind,
   input logic [2*N-1:0]    prec,
   input logic [N-1:0]      ta,
   input logic [N-1:0]      tb,
   input logic [N-1:0]      a_const,
   input logic [N-1:0]      b_const,
   input logic              taint_consts,
   input logic [NINV-1:0]   inv_a,
   input logic [NINV-1:0]   inv_ta,
   input logic [N-1:0]      ty,
   input logic [NINV-1:0]   inv_y,
   input logic [NINV-1:0]   inv_ty,
   input logic [COST_W-1:0] cost
);
   always_comb begin
      if (!$isunknown({kind, prec, ta, tb, a_const, b_const, taint_consts, ty})) begin
         for (int i = 0; i < N; i++) begin
            // no tainted input means no tainted output, any code
            if (!((a_const[i] ? taint_consts : ta[i]) | (b_const[i] ? taint_consts : tb[i])))
               assert_clean_in_clean_out_R6: assert (ty[i] == 1'b0);
            if (prec[2*i +: 2] == 2'b11)
               assert_coarse_union_R5: assert (ty[i] ==
                  ((a_const[i] ? taint_consts : ta[i]) | (b_const[i] ? taint_consts : tb[i])));
         end
      end
      if (!$isunknown({prec, cost})) begin
         assert_cost_in_range_R8: assert (int'(cost) <= 5 * N && int'(cost) >= N);
         if (&prec)
            assert_cost_all_coarse_R7: assert (int'(cost) == N);
         if (prec == '0)
            assert_no_overflow_R8: assert (int'(cost) == 5 * N);
      end
      if (!$isunknown({inv_a, inv_ta, inv_y, inv_ty})) begin
         assert_inv_passthru_R9: assert (inv_ty == inv_ta && inv_y == ~inv_a);
      end
   end
endmodule

bind taint_gate_array taint_gate_array_chk #(.N(N), .NINV(NINV), .COST_W(COST_W)) u_chk (
   .kind         (kind),
   .prec         (prec),
   .ta           (ta),
   .tb           (tb),
   .a_const      (a_const),
   .b_const      (b_const),
   .taint_consts (taint_consts),
   .inv_a        (inv_a),
   .inv_ta       (inv_ta),
   .ty           (ty),
   .inv_y        (inv_y),
   .inv_ty       (inv_ty),
   .cost         (cost)
);

// File: tb/taint_gate_array_tb.sv
module taint_gate_array_tb;
   localparam int N      = 7;
   localparam int NINV   = 2;
   localparam int COST_W = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [N-1:0]      kind, a, b, ta, tb, a_const, b_const;
   logic [2*N-1:0]    prec;
   logic              taint_consts;
   logic [NINV-1:0]   inv_a, inv_ta, inv_y, inv_ty;
   logic [N-1:0]      y, ty;
   logic [COST_W-1:0] cost;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   taint_gate_array #(.N(N), .NINV(NINV), .COST_W(COST_W)) u_dut (
      .kind(kind), .prec(prec), .a(a), .b(b), .ta(ta), .tb(tb),
      .a_const(a_const), .b_const(b_const), .taint_consts(taint_consts),
      .inv_a(inv_a), .inv_ta(inv_ta), .y(y), .ty(ty),
      .inv_y(inv_y), .inv_ty(inv_ty), .cost(cost)
   );

   // {kind, code[1:0], a, b, ta, tb, exp_y, exp_ty}
   localparam logic [8:0] TBL [12] = '{
      9'b0_00_1001_0_1, 9'b0_00_0001_0_0, 9'b1_00_1001_1_0, 9'b1_00_0101_1_1,
      9'b0_10_0001_0_1, 9'b0_10_0110_0_1, 9'b0_01_0110_0_1, 9'b0_01_0101_0_0,
      9'b1_10_1001_1_0, 9'b1_01_1001_1_1, 9'b1_11_1110_1_1, 9'b0_11_1100_1_0
   };

   function automatic string tag_of(input logic [1:0] c);
      case (c)
         2'b00:   return "R2";
         2'b10:   return "R3";
         2'b01:   return "R4";
         default: return "R5";
      endcase
   endfunction

   // expected taint from the requirement formulas
   function automatic logic model_t(input logic k, input logic [1:0] c,
                                    input logic av, bv, tav, tbv);
      case (c)
         2'b00: return k ? ((~av & tbv) | (~bv & tav) | (tav & tbv))
                         : ((av & tbv) | (bv & tav) | (tav & tbv));
         2'b10: return k ? (tav | (~av & tbv)) : (tbv | (bv & tav));
         2'b01: return k ? (tbv | (~bv & tav)) : (tav | (av & tbv));
         default: return tav | tbv;
      endcase
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic idle();
      kind = '0; prec = '0; a = '0; b = '0; ta = '0; tb = '0;
      a_const = '0; b_const = '0; taint_consts = 1'b0;
      inv_a = '0; inv_ta = '0;
   endtask

   task automatic lane0(input logic k, input logic [1:0] c,
                        input logic av, bv, tav, tbv);
      @(negedge clk);
      kind[0] = k; prec[1:0] = c; a[0] = av; b[0] = bv; ta[0] = tav; tb[0] = tbv;
      #1;
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      idle();
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // quiet state: all lanes exact AND, nothing tainted
      check("R6 idle ty", int'(ty), 0);
      check("R1 idle y", int'(y), 0);
      check("R8 idle cost", int'(cost), 35);

      // R2 R3 R4 R5 R1: table on lane 0
      for (int k = 0; k < 12; k++) begin
         lane0(TBL[k][8], TBL[k][7:6], TBL[k][5], TBL[k][4], TBL[k][3], TBL[k][2]);
         check({tag_of(TBL[k][7:6]), " table ty"}, int'(ty[0]), int'(TBL[k][0]));
         check("R1 table y", int'(y[0]), int'(TBL[k][1]));
      end

      // exhaustive per kind and code, plus conservativeness R6
      for (int k = 0; k < 2; k++)
         for (int c = 0; c < 4; c++)
            for (int v = 0; v < 16; v++) begin
               logic ex, tv;
               lane0(k[0], c[1:0], v[3], v[2], v[1], v[0]);
               tv = model_t(k[0], c[1:0], v[3], v[2], v[1], v[0]);
               ex = model_t(k[0], 2'b00, v[3], v[2], v[1], v[0]);
               check(tag_of(c[1:0]), int'(ty[0]), int'(tv));
               if (ex) check("R6 conservative", int'(ty[0]), 1);
               check("R1 sweep y", int'(y[0]), k ? int'(v[3] | v[2]) : int'(v[3] & v[2]));
            end

      // cost sums, odd lane count exercises tree pass-through
      @(negedge clk); idle(); prec = '1; #1;
      check("R7 all coarse cost", int'(cost), 7);
      @(negedge clk); prec = '0; #1;
      check("R8 all exact cost", int'(cost), 35);
      @(negedge clk); prec = {2'b10, 2'b01, 2'b00, 2'b11, 2'b10, 2'b01, 2'b00}; #1;
      check("R7 mixed cost", int'(cost), 19);
      @(negedge clk); prec = {2'b00, 2'b11, 2'b11, 2'b11, 2'b11, 2'b11, 2'b11}; #1;
      check("R8 last lane via pass-through", int'(cost), 11);
      // same cycle: lane 0 switched to coarse, taint and cost move together
      @(negedge clk); prec = '0; prec[1:0] = 2'b11; ta[0] = 1'b1; #1;
      check("R7 cost after one lane coarse", int'(cost), 31);
      check("R5 coarse ty same cycle", int'(ty[0]), 1);

      // constant labelling
      @(negedge clk); idle(); a = 7'h01; b = 7'h01; a_const[0] = 1'b1; ta[0] = 1'b1; #1;
      check("R10 const clean ignores ta", int'(ty[0]), 0);
      @(negedge clk); ta[0] = 1'b0; taint_consts = 1'b1; #1;
      check("R10 const tainted label", int'(ty[0]), 1);
      @(negedge clk); idle(); b_const[1] = 1'b1; tb[1] = 1'b1; a[1] = 1'b1; prec[3:2] = 2'b11; #1;
      check("R10 b const clean, coarse", int'(ty[1]), 0);

      // inverters
      @(negedge clk); inv_a = 2'b01; inv_ta = 2'b10; #1;
      check("R9 inv data", int'(inv_y), 2);
      check("R9 inv taint", int'(inv_ty), 2);
      @(negedge clk); inv_a = 2'b10; inv_ta = 2'b01; #1;
      check("R9 inv data 2", int'(inv_y), 1);
      check("R9 inv taint 2", int'(inv_ty), 1);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule